// File: doc/BRIEF.md
# Program Memory Read Guard

This block stands between a processor's code-space port and its two program stores: an internal mask ROM and an external program bus. For every code-space access it decides which store serves the access, or whether the access is refused. The choice rests on four things: the address, the kind of access (opcode fetch, operand byte fetch, table read or test-mode read), a mask-fixed security input, and the value of the external-access pin. The pin value is captured only while reset is held. After release, the pin has no effect whether or not security is on, so toggling the pin mid-instruction cannot move a fetch or a table read from the external bus onto the ROM.

A small state machine records where the current instruction's opcode came from. The state is `EX_HOLD` while reset is held. On leaving reset it moves to `EX_EXT`. From then on every opcode fetch moves it to `EX_INT` if the ROM served that fetch, or to `EX_EXT` otherwise. Operand, table and test accesses leave it unchanged.

With security on, an operand or table access that targets ROM while the machine is in `EX_HOLD` or `EX_EXT` is refused. A test-mode read of ROM is always refused. A refused access enables neither store, returns 8'hFF, and raises a violation pulse in the following cycle.

Top module: `code_read_guard`

## Requirements
- R1: While `rst_i` is 1, both enables are 0, `rd_data_o` is 8'hFF and `viol_o` is 0. The value on `ext_pin_i` in the last reset cycle sets the latched mode; a pin value of 1 means all code lives on the external bus.
- R2: After reset is released, changes on `ext_pin_i` alter no routing decision, whatever the value of `secure_i`.
- R3: With latched mode 0, an opcode fetch (`acc_kind_i` = 2'b00) whose address is below `ROM_SIZE` (default 16384, so 0x3FFF is the last ROM address) enables the ROM. Any other opcode fetch enables the external bus.
- R4: With latched mode 1, the ROM is never enabled by fetch, operand or table accesses; those accesses all go to the external bus.
- R5: The location state is updated only by opcode fetches (2'b00). It becomes `EX_INT` when the ROM served the fetch and `EX_EXT` otherwise. Operand fetches (2'b01) leave it unchanged. After reset it counts as external.
- R6: With `secure_i` = 1, a table read (2'b10) that targets ROM while the state is not `EX_INT` enables neither store and returns 8'hFF.
- R7: A table read issued while the state is `EX_INT`, or with `secure_i` = 0, is served by the ROM when it targets ROM. A table read above the ROM range goes to the external bus.
- R8: Operand fetches (2'b01) follow the same refusal rule as table reads.
- R9: With `secure_i` = 1, a test read (2'b11) of a ROM address is refused. With `secure_i` = 0 the ROM serves it. A test read beyond the ROM enables nothing and raises no violation. The latched mode does not affect test reads.
- R10: `viol_o` is 1 for exactly the one cycle that follows a refused access.
- R11: `rd_data_o` carries `rom_data_i` when the ROM is enabled and `ext_data_i` when the external bus is enabled; otherwise it is 8'hFF.
- R12: The two enables are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| secure_i | input | 1 | Mask-fixed security setting |
| ext_pin_i | input | 1 | External-access pin, 1 = all code external; sampled only in reset |
| acc_valid_i | input | 1 | A code-space access is presented this cycle |
| acc_kind_i | input | 2 | 00 opcode fetch, 01 operand fetch, 10 table read, 11 test read |
| addr_i | input | AW (16) | Code-space address |
| rom_data_i | input | 8 | Byte read from internal ROM |
| ext_data_i | input | 8 | Byte read from external program bus |
| rom_en_o | output | 1 | Internal ROM serves the access |
| ext_en_o | output | 1 | External bus serves the access |
| rd_data_o | output | 8 | Byte returned to the processor |
| viol_o | output | 1 | Pulse in the cycle after a refused access |

## Verification
The bench toggles the external-access pin right after every reset. A design that kept sampling the pin would then route ROM-range fetches to the wrong store. It places an opcode fetch from ROM and then one from the external bus ahead of a secure table read. A design that stuck to the first internal fetch, or that let operand fetches move the location state, would hand ROM bytes to external code. It probes addresses 0x3FFF and 0x4000, where an off-by-one compare would misroute, and it tests test-mode reads under both security settings and both pin values. It also checks that the violation flag falls after one cycle, which a design that held the flag high would fail.

// File: rtl/crg_pkg.sv
package crg_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_OPND  = 2'b01,
        ACC_TABLE = 2'b10,
        ACC_TEST  = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        EX_HOLD = 2'b00,
        EX_EXT  = 2'b01,
        EX_INT  = 2'b10
    } exec_state_e;

    localparam logic [7:0] BLANK_BYTE = 8'hFF;

endpackage

// File: rtl/crg_pin_latch.sv
module crg_pin_latch (
    input  logic clk_i,
    input  logic rst_i,
    input  logic pin_i,
    output logic ext_mode_o
);

    logic mode_q;

    // Capture the pin only while reset is held; hold it afterwards.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mode_q <= pin_i;
        end
    end

    assign ext_mode_o = mode_q;

    // R2
    pin_ignored_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !rst_i |=> $stable(ext_mode_o));

endmodule

// File: rtl/crg_exec_fsm.sv
module crg_exec_fsm
    import crg_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic fetch_hit_i,
    input  logic fetch_int_i,
    output logic exec_int_o
);

    exec_state_e state_q;
    exec_state_e state_d;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= EX_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EX_HOLD: begin
                if (fetch_hit_i && fetch_int_i) state_d = EX_INT;
                else                            state_d = EX_EXT;
            end
            EX_EXT: begin
                if (fetch_hit_i && fetch_int_i) state_d = EX_INT;
            end
            EX_INT: begin
                if (fetch_hit_i && !fetch_int_i) state_d = EX_EXT;
            end
            default: state_d = EX_EXT;
        endcase
    end

    always_comb begin
        exec_int_o = (state_q == EX_INT);
    end

    // R5
    fetch_int_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (fetch_hit_i && fetch_int_i) |=> exec_int_o);

    // R5
    fetch_ext_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (fetch_hit_i && !fetch_int_i) |=> !exec_int_o);

    // R5
    no_fetch_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!fetch_hit_i && state_q != EX_HOLD) |=> $stable(exec_int_o));

endmodule

// File: rtl/crg_route.sv
module crg_route
    import crg_pkg::*;
#(
    parameter int unsigned AW       = 16,
    parameter int unsigned ROM_SIZE = 16384
) (
    input  logic          clk_i,
    input  logic          in_reset_i,
    input  logic          valid_i,
    input  acc_kind_e     kind_i,
    input  logic [AW-1:0] addr_i,
    input  logic          ext_mode_i,
    input  logic          exec_int_i,
    input  logic          secure_i,
    output logic          rom_en_o,
    output logic          ext_en_o,
    output logic          blocked_o,
    output logic          fetch_hit_o,
    output logic          fetch_int_o
);

    localparam logic [AW:0] ROM_LIM = (AW+1)'(ROM_SIZE);

    logic in_rom;
    logic int_target;
    logic live;

    always_comb begin
        in_rom     = ({1'b0, addr_i} < ROM_LIM);
        int_target = in_rom && !ext_mode_i;
        live       = valid_i && !in_reset_i;
    end

    always_comb begin
        rom_en_o  = 1'b0;
        ext_en_o  = 1'b0;
        blocked_o = 1'b0;
        if (live) begin
            unique case (kind_i)
                ACC_FETCH: begin
                    rom_en_o = int_target;
                    ext_en_o = !int_target;
                end
                ACC_OPND, ACC_TABLE: begin
                    if (!int_target)                   ext_en_o  = 1'b1;
                    else if (secure_i && !exec_int_i)  blocked_o = 1'b1;
                    else                               rom_en_o  = 1'b1;
                end
                ACC_TEST: begin
                    if (in_rom) begin
                        if (secure_i) blocked_o = 1'b1;
                        else          rom_en_o  = 1'b1;
                    end
                end
                default: blocked_o = 1'b0;
            endcase
        end
        fetch_hit_o = live && (kind_i == ACC_FETCH);
        fetch_int_o = fetch_hit_o && int_target;
    end

    // R4
    forced_ext_chk: assert property (@(posedge clk_i) disable iff (in_reset_i)
        (ext_mode_i && kind_i != ACC_TEST) |-> !rom_en_o);

    // R9
    test_secure_chk: assert property (@(posedge clk_i) disable iff (in_reset_i)
        (valid_i && kind_i == ACC_TEST && secure_i) |-> (!rom_en_o && !ext_en_o));

    // R6
    ext_exec_table_chk: assert property (@(posedge clk_i) disable iff (in_reset_i)
        (valid_i && kind_i == ACC_TABLE && secure_i && !exec_int_i) |-> !rom_en_o);

    // R8
    ext_exec_opnd_chk: assert property (@(posedge clk_i) disable iff (in_reset_i)
        (valid_i && kind_i == ACC_OPND && secure_i && !exec_int_i) |-> !rom_en_o);

endmodule

// File: rtl/code_read_guard.sv
module code_read_guard
    import crg_pkg::*;
#(
    parameter int unsigned AW       = 16,
    parameter int unsigned ROM_SIZE = 16384
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          secure_i,
    input  logic          ext_pin_i,
    input  logic          acc_valid_i,
    input  logic [1:0]    acc_kind_i,
    input  logic [AW-1:0] addr_i,
    input  logic [7:0]    rom_data_i,
    input  logic [7:0]    ext_data_i,
    output logic          rom_en_o,
    output logic          ext_en_o,
    output logic [7:0]    rd_data_o,
    output logic          viol_o
);

    logic      ext_mode;
    logic      exec_int;
    logic      blocked;
    logic      fetch_hit;
    logic      fetch_int;
    logic      viol_q;
    acc_kind_e kind;

    assign kind = acc_kind_e'(acc_kind_i);

    crg_pin_latch u_latch (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .pin_i      (ext_pin_i),
        .ext_mode_o (ext_mode)
    );

    crg_route #(
        .AW       (AW),
        .ROM_SIZE (ROM_SIZE)
    ) u_route (
        .clk_i       (clk_i),
        .in_reset_i  (rst_i),
        .valid_i     (acc_valid_i),
        .kind_i      (kind),
        .addr_i      (addr_i),
        .ext_mode_i  (ext_mode),
        .exec_int_i  (exec_int),
        .secure_i    (secure_i),
        .rom_en_o    (rom_en_o),
        .ext_en_o    (ext_en_o),
        .blocked_o   (blocked),
        .fetch_hit_o (fetch_hit),
        .fetch_int_o (fetch_int)
    );

    crg_exec_fsm u_fsm (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .fetch_hit_i (fetch_hit),
        .fetch_int_i (fetch_int),
        .exec_int_o  (exec_int)
    );

    always_comb begin
        unique case ({rom_en_o, ext_en_o})
            2'b10:   rd_data_o = rom_data_i;
            2'b01:   rd_data_o = ext_data_i;
            default: rd_data_o = BLANK_BYTE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) viol_q <= 1'b0;
        else       viol_q <= blocked;
    end

    assign viol_o = viol_q;

    // R12
    one_enable_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(rom_en_o && ext_en_o));

    // R10
    viol_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        blocked |=> viol_o);

    // R10
    viol_drop_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (viol_o && !blocked) |=> !viol_o);

    // R11
    blank_data_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!rom_en_o && !ext_en_o) |-> (rd_data_o == 8'hFF));

    // R6
    refused_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        blocked |-> (!rom_en_o && !ext_en_o));

endmodule

// File: tb/code_read_guard_test.sv
`timescale 1ns/1ps
module code_read_guard_test;

    logic        clk_i = 1'b0;
    logic        rst_i = 1'b1;
    logic        secure_i = 1'b0;
    logic        ext_pin_i = 1'b0;
    logic        acc_valid_i = 1'b0;
    logic [1:0]  acc_kind_i = 2'b00;
    logic [15:0] addr_i = 16'h0000;
    logic [7:0]  rom_data_i;
    logic [7:0]  ext_data_i;
    logic        rom_en_o;
    logic        ext_en_o;
    logic [7:0]  rd_data_o;
    logic        viol_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk_i = ~clk_i;

    assign rom_data_i = addr_i[7:0] ^ 8'h5A;
    assign ext_data_i = addr_i[7:0] ^ 8'hA5;

    code_read_guard uut (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .secure_i    (secure_i),
        .ext_pin_i   (ext_pin_i),
        .acc_valid_i (acc_valid_i),
        .acc_kind_i  (acc_kind_i),
        .addr_i      (addr_i),
        .rom_data_i  (rom_data_i),
        .ext_data_i  (ext_data_i),
        .rom_en_o    (rom_en_o),
        .ext_en_o    (ext_en_o),
        .rd_data_o   (rd_data_o),
        .viol_o      (viol_o)
    );

    // {secure, pin, loc_int}, kind, tgt_in_rom, {exp_rom, exp_ext, exp_viol}
    localparam int NV = 20;
    localparam logic [8:0] VEC [NV] = '{
        9'b000_00_1_100, 9'b000_00_0_010, 9'b010_00_1_010, 9'b100_00_1_100,
        9'b000_10_1_100, 9'b100_10_1_001, 9'b101_10_1_100, 9'b101_10_0_010,
        9'b100_10_0_010, 9'b111_10_1_010, 9'b100_01_1_001, 9'b101_01_1_100,
        9'b000_01_1_100, 9'b101_11_1_001, 9'b000_11_1_100, 9'b010_11_1_100,
        9'b110_11_0_000, 9'b001_10_1_100, 9'b110_01_1_010, 9'b011_10_1_010
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_port(input string req, input bit er, input bit ee);
        logic [7:0] ed;
        ed = er ? (addr_i[7:0] ^ 8'h5A) : (ee ? (addr_i[7:0] ^ 8'hA5) : 8'hFF);
        check(rom_en_o == er && ext_en_o == ee && rd_data_o == ed, req,
              {rom_en_o, ext_en_o, rd_data_o}, {er, ee, ed});
    endtask

    task automatic reset_dut(input bit sec, input bit pin);
        @(negedge clk_i);
        rst_i = 1'b1; secure_i = sec; ext_pin_i = pin; acc_valid_i = 1'b0;
        repeat (3) @(negedge clk_i);
        rst_i = 1'b0;
        ext_pin_i = !pin;   // toggle after release; must be ignored (R2)
    endtask

    task automatic access(input logic [1:0] k, input logic [15:0] a);
        @(negedge clk_i);
        acc_valid_i = 1'b1; acc_kind_i = k; addr_i = a;
        #1;
    endtask

    task automatic idle();
        @(negedge clk_i);
        acc_valid_i = 1'b0;
        #1;
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: outputs quiet while reset is held, even with an access presented
        repeat (2) @(negedge clk_i);
        acc_valid_i = 1'b1; acc_kind_i = 2'b00; addr_i = 16'h0100;
        #1;
        check_port("R1 reset outputs", 1'b0, 1'b0);
        check(viol_o == 1'b0, "R1 reset viol", viol_o, 0);

        // Vector table: R2 R3 R4 R6 R7 R8 R9 R11 R12
        for (int i = 0; i < NV; i++) begin
            logic [8:0] v;
            v = VEC[i];
            reset_dut(v[8], v[7]);
            access(2'b00, v[6] ? 16'h0100 : 16'h8000);
            access(v[5:4], v[3] ? 16'h0234 : 16'h9234);
            check_port($sformatf("R2/R3/R4/R6/R7/R8/R9/R11 vec%0d", i), v[2], v[1]);
            idle();
            check(viol_o == v[0], $sformatf("R10 vec%0d viol", i), viol_o, v[0]);
        end

        // R3: ROM range boundary
        reset_dut(1'b0, 1'b0);
        access(2'b00, 16'h3FFF);
        check_port("R3 last ROM address", 1'b1, 1'b0);
        access(2'b00, 16'h4000);
        check_port("R3 first external address", 1'b0, 1'b1);

        // R1 R4: pin latched at 1 forces external; toggling to 0 is ignored (R2)
        reset_dut(1'b0, 1'b1);
        access(2'b00, 16'h0010);
        check_port("R4 forced external fetch", 1'b0, 1'b1);
        ext_pin_i = 1'b1;
        #1;
        ext_pin_i = 1'b0;
        access(2'b10, 16'h0020);
        check_port("R2 pin toggle mid-run", 1'b0, 1'b1);

        // R5: latest opcode fetch decides location
        reset_dut(1'b1, 1'b0);
        access(2'b00, 16'h0100);
        access(2'b00, 16'h8000);
        access(2'b10, 16'h0234);
        check_port("R5 later external fetch blocks", 1'b0, 1'b0);
        idle();
        check(viol_o == 1'b1, "R10 pulse high", viol_o, 1);
        idle();
        check(viol_o == 1'b0, "R10 pulse one cycle", viol_o, 0);

        // R5: operand fetch from external address does not move location
        access(2'b00, 16'h0100);
        access(2'b01, 16'h8001);
        check_port("R5 operand external served", 1'b0, 1'b1);
        access(2'b10, 16'h0234);
        check_port("R5 operand keeps internal location", 1'b1, 1'b0);

        // R5: right after reset the location counts as external
        reset_dut(1'b1, 1'b0);
        access(2'b10, 16'h0234);
        check_port("R5 post-reset location external", 1'b0, 1'b0);
        idle();

        // R7: internal code reads top ROM byte and above-ROM byte
        access(2'b00, 16'h0100);
        access(2'b10, 16'h3FFF);
        check_port("R7 internal table top of ROM", 1'b1, 1'b0);
        access(2'b10, 16'h4000);
        check_port("R7 internal table above ROM", 1'b0, 1'b1);
        idle();
        check(viol_o == 1'b0, "R10 no pulse when allowed", viol_o, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule